// File: doc/BRIEF.md
# Serial-to-Frame Packetiser with Idle Flush

This block sits behind one serial receiver and groups the bytes it delivers into frames for a packet network. Bytes arrive one per `in_valid` pulse and are first held in a small staging ring. Once that ring holds a full chunk of bytes, the chunk moves one byte per cycle into a larger circular store. While the store is empty, the output reads straight from the staging ring, so short bursts never pass through the store.

A frame is closed on one of two conditions. The first is that the count of unframed bytes reaches the maximum frame size. The second is that the receive line has stayed quiet for a set number of character times. One character time is `baud_div` clock cycles per bit multiplied by the bits per character. When a frame closes, its length goes into a short length queue. An emitter then streams that many bytes on a valid/ready port and marks the final byte.

When the output is held off, bytes keep collecting in the staging ring and the store. A byte that cannot be stored is dropped, and a sticky flag records the loss.

Top module: `serial_framer`

## Requirements
- R1: During and right after reset, `out_valid` and `overflow` are low.
- R2: Every accepted byte leaves on `out_data` exactly once, unaltered and in arrival order.
- R3: The unframed byte count closes a frame when it reaches MAX_FRAME. `out_last` is high on that frame's MAX_FRAME-th byte, and no frame is longer than MAX_FRAME.
- R4: If fewer than MAX_FRAME bytes are pending, a frame closes once no byte has been accepted for IDLE_CHARS x BITS_PER_CHAR x `baud_div` cycles. Its first byte appears on the port two cycles after the timer threshold is reached.
- R5: Each accepted byte restarts the idle timer, so bytes spaced by less than the idle limit stay in one frame.
- R6: The idle timer is disarmed while no byte is pending, so an empty frame is never produced.
- R7: `baud_div` (clock cycles per serial bit) scales the idle limit linearly.
- R8: Full chunks of CHUNK bytes move from the staging ring to the store. The output reads the store first and the staging ring only while the store is empty. Up to STAGE_DEPTH+STORE_DEPTH bytes can be held under back-pressure with no loss.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` hold their values into the next cycle.
- R10: A byte offered while the staging ring is full is dropped and sets `overflow` (active high), which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_div | input | DIV_W | Clock cycles per serial bit |
| in_valid | input | 1 | A received byte is present |
| in_data | input | 8 | Received byte |
| out_ready | input | 1 | Sink accepts the output byte |
| out_valid | output | 1 | Output byte is valid |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Output byte ends its frame |
| overflow | output | 1 | Sticky byte-loss flag |

## Verification
The bench probes the idle threshold from both sides. It expects silence shortly before the limit and a frame shortly after it, for two divisor values. A timer that ignored the divisor or counted from the wrong byte would be early or late. Bytes spaced just inside the limit must form one frame, which catches a timer that is not restarted. A long quiet period after a flush must produce nothing, which catches an empty frame.

A back-to-back burst of more than two maximum frames checks where the size cutoff falls. A held-off burst that fills the store without loss checks the chunk move and bypass ordering, and a stalled output must keep its byte steady. A deliberate over-fill must deliver exactly the stored capacity and leave the flag set. A design that counted dropped bytes, or cleared the flag, would fail there.

// File: rtl/pf_pkg.sv
package pf_pkg;
    localparam int BYTE_W = 8;
    typedef logic [BYTE_W-1:0] pf_byte_t;
endpackage

// File: rtl/pf_ring.sv
// Circular buffer with a combinational head read. DEPTH must be a power of two.
module pf_ring #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [WIDTH-1:0]             wdata,
    input  logic                         pop,
    output logic [WIDTH-1:0]             rdata,
    output logic [$clog2(DEPTH+1)-1:0]   count
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } ring_t;

    ring_t ring_q, ring_d;
    logic [WIDTH-1:0] mem_q [DEPTH];
    logic do_push, do_pop;

    always_comb begin
        do_push = push && (ring_q.cnt != CW'(DEPTH));
        do_pop  = pop  && (ring_q.cnt != '0);
        ring_d  = ring_q;
        if (do_push) ring_d.wp = ring_q.wp + AW'(1);
        if (do_pop)  ring_d.rp = ring_q.rp + AW'(1);
        case ({do_push, do_pop})
            2'b10:   ring_d.cnt = ring_q.cnt + CW'(1);
            2'b01:   ring_d.cnt = ring_q.cnt - CW'(1);
            default: ring_d.cnt = ring_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ring_q <= '0;
        else        ring_q <= ring_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[ring_q.wp] <= wdata;
    end

    assign rdata = mem_q[ring_q.rp];
    assign count = ring_q.cnt;
endmodule

// File: rtl/pf_idle_timer.sv
// Counts cycles since the last restart, saturating at the limit.
module pf_idle_timer #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    input  logic         armed,
    input  logic [W-1:0] limit,
    output logic         expired
);
    logic [W-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (restart)            cnt_d = '0;
        else if (cnt_q < limit) cnt_d = cnt_q + W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = armed && (cnt_q >= limit);
endmodule

// File: rtl/serial_framer.sv
module serial_framer #(
    parameter int MAX_FRAME     = 1500,
    parameter int IDLE_CHARS    = 10,
    parameter int BITS_PER_CHAR = 10,
    parameter int DIV_W         = 16,
    parameter int STAGE_DEPTH   = 16,
    parameter int CHUNK         = 8,
    parameter int STORE_DEPTH   = 2048,
    parameter int LENQ_DEPTH    = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [DIV_W-1:0]      baud_div,
    input  logic                  in_valid,
    input  logic [7:0]            in_data,
    input  logic                  out_ready,
    output logic                  out_valid,
    output logic [7:0]            out_data,
    output logic                  out_last,
    output logic                  overflow
);
    import pf_pkg::*;

    localparam int PW       = $clog2(MAX_FRAME + 1);
    localparam int CKW      = $clog2(CHUNK + 1);
    localparam int STG_CW   = $clog2(STAGE_DEPTH + 1);
    localparam int STO_CW   = $clog2(STORE_DEPTH + 1);
    localparam int LQ_CW    = $clog2(LENQ_DEPTH + 1);
    localparam int GAP_BITS = IDLE_CHARS * BITS_PER_CHAR;
    localparam int LIM_W    = DIV_W + $clog2(GAP_BITS + 1);

    typedef struct packed {
        logic [PW-1:0]  pending;
        logic           ovf;
        logic           active;
        logic [PW-1:0]  remain;
        logic           mv_active;
        logic [CKW-1:0] mv_left;
    } fr_state_t;

    fr_state_t st_q, st_d;

    // ring interconnect
    pf_byte_t            stage_rdata, store_rdata;
    logic [STG_CW-1:0]   stage_cnt;
    logic [STO_CW-1:0]   store_cnt;
    logic [PW-1:0]       lenq_rdata;
    logic [LQ_CW-1:0]    lenq_cnt;
    logic                stage_push, stage_pop, store_push, store_pop;
    logic                lenq_push, lenq_pop;

    logic                stage_full, stage_empty, store_empty, lenq_full, lenq_empty;
    logic                src_store, fire, fire_stage;
    logic                close_req, close_ok, accept, idle_exp, mv_go;
    logic [LIM_W-1:0]    idle_limit;
    int                  stage_after, store_after;

    assign idle_limit = LIM_W'(baud_div) * LIM_W'(GAP_BITS);

    pf_ring #(.WIDTH(8), .DEPTH(STAGE_DEPTH)) u_stage (
        .clk(clk), .rst_n(rst_n),
        .push(stage_push), .wdata(in_data),
        .pop(stage_pop), .rdata(stage_rdata), .count(stage_cnt)
    );

    pf_ring #(.WIDTH(8), .DEPTH(STORE_DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n),
        .push(store_push), .wdata(stage_rdata),
        .pop(store_pop), .rdata(store_rdata), .count(store_cnt)
    );

    pf_ring #(.WIDTH(PW), .DEPTH(LENQ_DEPTH)) u_lenq (
        .clk(clk), .rst_n(rst_n),
        .push(lenq_push), .wdata(st_q.pending),
        .pop(lenq_pop), .rdata(lenq_rdata), .count(lenq_cnt)
    );

    pf_idle_timer #(.W(LIM_W)) u_idle (
        .clk(clk), .rst_n(rst_n),
        .restart(accept),
        .armed(st_q.pending != '0),
        .limit(idle_limit),
        .expired(idle_exp)
    );

    always_comb begin
        stage_full  = (stage_cnt == STG_CW'(STAGE_DEPTH));
        stage_empty = (stage_cnt == '0);
        store_empty = (store_cnt == '0);
        lenq_full   = (lenq_cnt == LQ_CW'(LENQ_DEPTH));
        lenq_empty  = (lenq_cnt == '0);

        // output side: the store holds older bytes, so it goes first
        src_store  = !store_empty;
        out_valid  = st_q.active && (src_store || !stage_empty);
        out_data   = src_store ? store_rdata : stage_rdata;
        out_last   = out_valid && (st_q.remain == PW'(1));
        fire       = out_valid && out_ready;
        fire_stage = fire && !src_store;

        // a byte taken by the output while the mover runs is not copied
        stage_pop  = st_q.mv_active || fire_stage;
        store_push = st_q.mv_active && !fire_stage;
        store_pop  = fire && src_store;

        // frame closing
        close_req = (st_q.pending == PW'(MAX_FRAME)) || idle_exp;
        close_ok  = close_req && !lenq_full;
        lenq_push = close_ok;
        lenq_pop  = !st_q.active && !lenq_empty;

        // input acceptance
        accept     = in_valid && !stage_full &&
                     ((st_q.pending != PW'(MAX_FRAME)) || close_ok);
        stage_push = accept;

        // chunk mover start decision, on the occupancy after this cycle
        stage_after = int'(stage_cnt) - (stage_pop ? 1 : 0);
        store_after = int'(store_cnt) + (store_push ? 1 : 0) - (store_pop ? 1 : 0);
        mv_go = (!st_q.mv_active || (st_q.mv_left == CKW'(1))) &&
                (stage_after >= CHUNK) &&
                ((STORE_DEPTH - store_after) >= CHUNK);

        st_d = st_q;

        if (close_ok) st_d.pending = accept ? PW'(1) : '0;
        else          st_d.pending = st_q.pending + PW'(accept);

        st_d.ovf = st_q.ovf || (in_valid && !accept);

        if (lenq_pop) begin
            st_d.active = 1'b1;
            st_d.remain = lenq_rdata;
        end else if (fire) begin
            if (st_q.remain == PW'(1)) st_d.active = 1'b0;
            st_d.remain = st_q.remain - PW'(1);
        end

        if (st_q.mv_active) begin
            st_d.mv_left = st_q.mv_left - CKW'(1);
            if (st_q.mv_left == CKW'(1)) st_d.mv_active = 1'b0;
        end
        if (mv_go) begin
            st_d.mv_active = 1'b1;
            st_d.mv_left   = CKW'(CHUNK);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign overflow = st_q.ovf;
endmodule

// File: rtl/serial_framer_checker.sv
module serial_framer_checker #(
    parameter int MAX_FRAME = 1500
) (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic       out_valid,
    input logic       out_ready,
    input logic [7:0] out_data,
    input logic       out_last,
    input logic       overflow
);
    localparam int BW = $clog2(MAX_FRAME + 1);
    logic [BW-1:0] beats_q;

    always_ff @(posedge clk) begin
        if (!rst_n)                      beats_q <= '0;
        else if (out_valid && out_ready) beats_q <= out_last ? '0 : beats_q + BW'(1);
    end

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

    assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    assert_loss_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow) |-> $past(in_valid));

    assert_max_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (beats_q == BW'(MAX_FRAME - 1))) |-> out_last);
endmodule

bind serial_framer serial_framer_checker #(.MAX_FRAME(MAX_FRAME)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last), .overflow(overflow)
);

// File: tb/serial_framer_test.sv
`timescale 1ns/1ps
module serial_framer_test;
    localparam int MAXF = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [15:0] baud_div = 16'd1;
    logic in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic out_ready = 1'b0;
    logic out_valid, out_last, overflow;
    logic [7:0] out_data;

    always #5 clk = ~clk;

    serial_framer #(
        .MAX_FRAME(MAXF), .IDLE_CHARS(10), .BITS_PER_CHAR(10), .DIV_W(16),
        .STAGE_DEPTH(8), .CHUNK(4), .STORE_DEPTH(16), .LENQ_DEPTH(4)
    ) uut (
        .clk(clk), .rst_n(rst_n), .baud_div(baud_div),
        .in_valid(in_valid), .in_data(in_data), .out_ready(out_ready),
        .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
        .overflow(overflow)
    );

    int n_chk = 0, n_fail = 0;
    int beats = 0, frames = 0;
    int model_cnt = 0;
    bit sb_en = 1'b1, done = 1'b0;
    logic [7:0] next_val = 8'h10;
    logic [7:0] dq[$];
    bit lq[$];

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // expected-frame model
    task automatic model_push(input logic [7:0] b);
        dq.push_back(b);
        lq.push_back(1'b0);
        model_cnt++;
        if (model_cnt == MAXF) begin
            lq[lq.size()-1] = 1'b1;
            model_cnt = 0;
        end
    endtask

    task automatic model_flush();
        if (model_cnt > 0) begin
            lq[lq.size()-1] = 1'b1;
            model_cnt = 0;
        end
    endtask

    task automatic send_byte();
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = next_val;
        if (sb_en) model_push(next_val);
        next_val = next_val + 8'd1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic burst(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = next_val;
            if (sb_en) model_push(next_val);
            next_val = next_val + 8'd1;
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready) begin
            beats++;
            if (out_last) frames++;
            if (sb_en) begin
                if (dq.size() == 0) begin
                    check(1'b0, "R6", "beat with nothing expected", int'(out_data), -1);
                end else begin
                    logic [7:0] ed;
                    bit el;
                    ed = dq.pop_front();
                    el = lq.pop_front();
                    check(out_data == ed, "R2", "byte value/order", int'(out_data), int'(ed));
                    check(out_last == el, "R3 R4 R5", "frame end marker", int'(out_last), int'(el));
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int f0, b0;
        logic [7:0] held;

        wait_cyc(4);
        check(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
        check(overflow == 1'b0, "R1", "overflow in reset", int'(overflow), 0);
        rst_n = 1'b1;
        wait_cyc(3);
        check(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
        check(overflow == 1'b0, "R1", "overflow after reset", int'(overflow), 0);

        // R4: idle flush timing, divisor 1 -> limit 100 cycles
        out_ready = 1'b0;
        send_byte(); send_byte(); send_byte();
        model_flush();
        wait_cyc(95);
        check(out_valid == 1'b0, "R4", "no frame before idle limit", int'(out_valid), 0);
        wait_cyc(11);
        check(out_valid == 1'b1, "R4", "frame after idle limit", int'(out_valid), 1);
        out_ready = 1'b1;
        wait_cyc(10);

        // R6: nothing pending, long quiet time
        f0 = frames;
        wait_cyc(300);
        check(out_valid == 1'b0, "R6", "no empty frame", int'(out_valid), 0);
        check(frames == f0, "R6", "frame count while empty", frames, f0);

        // R5: gaps shorter than the limit stay in one frame
        f0 = frames;
        for (int i = 0; i < 4; i++) begin
            send_byte();
            wait_cyc(80);
        end
        model_flush();
        wait_cyc(130);
        check(frames == f0 + 1, "R5", "frames from spaced bytes", frames, f0 + 1);

        // R7: divisor 3 -> limit 300 cycles
        baud_div = 16'd3;
        out_ready = 1'b0;
        send_byte(); send_byte();
        model_flush();
        wait_cyc(290);
        check(out_valid == 1'b0, "R7", "no frame before scaled limit", int'(out_valid), 0);
        wait_cyc(20);
        check(out_valid == 1'b1, "R7", "frame after scaled limit", int'(out_valid), 1);
        out_ready = 1'b1;
        wait_cyc(10);
        baud_div = 16'd1;

        // R3: back-to-back burst of 30 bytes -> 12, 12, then 6 by idle
        f0 = frames;
        burst(30);
        model_flush();
        wait_cyc(150);
        check(frames == f0 + 3, "R3", "frames from long burst", frames, f0 + 3);

        // R8 / R9: held-off burst within capacity
        out_ready = 1'b0;
        f0 = frames;
        burst(20);
        wait_cyc(5);
        check(out_valid == 1'b1, "R9", "valid while held", int'(out_valid), 1);
        held = out_data;
        wait_cyc(3);
        check(out_data == held, "R9", "data held under back-pressure", int'(out_data), int'(held));
        check(out_valid == 1'b1, "R9", "valid still held", int'(out_valid), 1);
        check(overflow == 1'b0, "R8", "no loss within capacity", int'(overflow), 0);
        model_flush();
        wait_cyc(150);
        out_ready = 1'b1;
        wait_cyc(40);
        check(frames == f0 + 2, "R8", "frames after held burst", frames, f0 + 2);
        check(dq.size() == 0, "R2", "expected bytes left over", dq.size(), 0);

        // R10: over-fill by 6 bytes
        sb_en = 1'b0;
        out_ready = 1'b0;
        f0 = frames;
        b0 = beats;
        burst(30);
        wait_cyc(2);
        check(overflow == 1'b1, "R10", "overflow after over-fill", int'(overflow), 1);
        wait_cyc(150);
        out_ready = 1'b1;
        wait_cyc(300);
        check(beats - b0 == 24, "R10", "bytes delivered after loss", beats - b0, 24);
        check(frames - f0 == 2, "R10", "frames delivered after loss", frames - f0, 2);
        check(overflow == 1'b1, "R10", "overflow stays set", int'(overflow), 1);
        check(out_valid == 1'b0, "R6", "idle after drain", int'(out_valid), 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule